// File: doc/BRIEF.md
# Pin Change Interrupt Detector

This block watches a group of already-synchronized input pins and raises one sticky change flag when any enabled pin differs from a reference copy of the pins. The reference copy is not refreshed every clock. It is refreshed only when software reads or writes the port, which the surrounding logic signals with a one-cycle access strobe. A set flag also drives a wake request, so a sleeping system can resume when a watched pin moves.

Software clears the flag with a clear strobe. A live difference between the pins and the reference copy keeps setting the flag again. The handler therefore has to access the port first, which refreshes the copy and ends the difference, and only then clear the flag.

There are two reset inputs. The power-on reset initialises everything. The other, general, reset clears only the flag. The reference copy and the enable mask survive a general reset, so a difference that is still present sets the flag again once that reset is released. Both resets act asynchronously, and their release is synchronized inside the block.

Top module: `pin_change_detect`

## Requirements
- R1: The per-pin enable mask is loaded from `en_d_i` in any cycle where `en_we_i` is 1, and takes effect from the next cycle. Bit n enables pin n.
- R2: A pin whose enable bit is 0 never contributes to the flag, whatever its value.
- R3: If any enabled pin differs from its reference bit in a cycle, the flag is 1 after that clock edge.
- R4: `clr_i` clears the flag at the clock edge only when no enabled pin differs in that cycle. A difference in the same cycle wins, and the flag stays 1.
- R5: `port_acc_i` loads the reference copy with the pin values of that same cycle. The comparison in that cycle still uses the old reference, so a change that coincides with an access sets the flag.
- R6: While `rst_n` is low the flag is 0. The reference copy and the enable mask keep their values, and after release the flag is set again if a difference is present.
- R7: While `por_n` is low the flag is 0 and all enables are 0. At the first clock after release, the reference copy takes the current pin values.
- R8: `wake_o` equals the flag at all times.
- R9: With no difference and no clear strobe, the flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | General reset, asynchronous, active low; clears only the flag |
| pins_i | input | NPINS | Synchronized pin values |
| en_we_i | input | 1 | Enable mask write strobe |
| en_d_i | input | NPINS | Enable mask write data |
| port_acc_i | input | 1 | Port read-or-write strobe; refreshes the reference copy |
| clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky change flag |
| wake_o | output | 1 | Wake request |

## Verification
The clear strobe and a pin difference can arrive in the same cycle. So can a port access and a pin change. The bench provokes the first by raising `clr_i` while an enabled pin still differs, and it expects the flag to remain 1. It provokes the second by driving a new pin value in the very cycle of `port_acc_i`, and it expects the flag to set. It then issues a clear to confirm that the reference copy captured the pins of that cycle.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int PCD_DEF_PINS   = 6;
  localparam int PCD_SYNC_STAGE = 2;

  typedef enum logic [1:0] {
    FLAG_HOLD  = 2'd0,
    FLAG_SET   = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_op_e;

endpackage

// File: rtl/pcd_rst_sync.sv
module pcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pcd_snapshot.sv
module pcd_snapshot #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             por_rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             port_acc_i,
  input  logic             en_we_i,
  input  logic [NPINS-1:0] en_d_i,
  output logic [NPINS-1:0] snap_o,
  output logic             snap_vld_o,
  output logic [NPINS-1:0] en_o
);

  logic [NPINS-1:0] snap_q, snap_d;
  logic [NPINS-1:0] en_q, en_d;
  logic             vld_q, vld_d;
  logic             snap_ce;

  // Reference copy loads on the first clock after power-on and on every access.
  always_comb begin
    snap_ce = port_acc_i | ~vld_q;
    snap_d  = snap_ce ? pins_i : snap_q;
    vld_d   = 1'b1;
    en_d    = en_we_i ? en_d_i : en_q;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      snap_q <= '0;
      vld_q  <= 1'b0;
      en_q   <= '0;
    end else begin
      snap_q <= snap_d;
      vld_q  <= vld_d;
      en_q   <= en_d;
    end
  end

  assign snap_o     = snap_q;
  assign snap_vld_o = vld_q;
  assign en_o       = en_q;

endmodule

// File: rtl/pcd_mismatch.sv
module pcd_mismatch #(
  parameter int NPINS = 6
) (
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] snap_i,
  input  logic [NPINS-1:0] en_i,
  input  logic             snap_vld_i,
  output logic [NPINS-1:0] diff_o,
  output logic             any_o
);

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
      assign diff_o[g] = en_i[g] & snap_vld_i & (pins_i[g] ^ snap_i[g]);
    end
  endgenerate

  assign any_o = |diff_o;

endmodule

// File: rtl/pcd_flag.sv
module pcd_flag
  import pcd_pkg::*;
(
  input  logic clk,
  input  logic sys_rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  flag_op_e op;
  logic     flag_q, flag_d;

  // Setting has priority over clearing.
  always_comb begin
    if (set_i)      op = FLAG_SET;
    else if (clr_i) op = FLAG_CLEAR;
    else            op = FLAG_HOLD;
    case (op)
      FLAG_SET:   flag_d = 1'b1;
      FLAG_CLEAR: flag_d = 1'b0;
      default:    flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) flag_q <= 1'b0;
    else            flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
  import pcd_pkg::*;
#(
  parameter int NPINS       = PCD_DEF_PINS,
  parameter int SYNC_STAGES = PCD_SYNC_STAGE
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             en_we_i,
  input  logic [NPINS-1:0] en_d_i,
  input  logic             port_acc_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             wake_o
);

  logic             por_rst_n_s;
  logic             sys_rst_n_s;
  logic             sys_arst_n;
  logic [NPINS-1:0] snap_q;
  logic             snap_vld;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] diff_vec;
  logic             any_mism;
  logic             flag_q;

  assign sys_arst_n = por_n & rst_n;

  pcd_rst_sync #(.STAGES(SYNC_STAGES)) i_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_rst_n_s)
  );

  pcd_rst_sync #(.STAGES(SYNC_STAGES)) i_sys_sync (
    .clk    (clk),
    .arst_n (sys_arst_n),
    .srst_n (sys_rst_n_s)
  );

  pcd_snapshot #(.NPINS(NPINS)) i_snap (
    .clk        (clk),
    .por_rst_n  (por_rst_n_s),
    .pins_i     (pins_i),
    .port_acc_i (port_acc_i),
    .en_we_i    (en_we_i),
    .en_d_i     (en_d_i),
    .snap_o     (snap_q),
    .snap_vld_o (snap_vld),
    .en_o       (en_q)
  );

  pcd_mismatch #(.NPINS(NPINS)) i_cmp (
    .pins_i     (pins_i),
    .snap_i     (snap_q),
    .en_i       (en_q),
    .snap_vld_i (snap_vld),
    .diff_o     (diff_vec),
    .any_o      (any_mism)
  );

  pcd_flag i_flag (
    .clk       (clk),
    .sys_rst_n (sys_rst_n_s),
    .set_i     (any_mism),
    .clr_i     (clr_i),
    .flag_o    (flag_q)
  );

  assign flag_o = flag_q;
  assign wake_o = flag_q;

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int NPINS = 6
) (
  input logic             clk,
  input logic             sys_rst_n,
  input logic             por_rst_n,
  input logic             mism,
  input logic             clr,
  input logic             flag,
  input logic             acc,
  input logic             vld,
  input logic [NPINS-1:0] pins,
  input logic [NPINS-1:0] snap
);

  p_set_r3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    mism |=> flag);

  p_clr_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!mism && clr) |=> !flag);

  p_hold_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!mism && !clr) |=> (flag == $past(flag)));

  p_reload_r5: assert property (@(posedge clk) disable iff (!por_rst_n)
    (acc && vld) |=> (snap == $past(pins)));

  p_keep_r5: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!acc && vld) |=> $stable(snap));

  p_first_r7: assert property (@(posedge clk) disable iff (!por_rst_n)
    !vld |=> (vld && snap == $past(pins)));

endmodule

bind pin_change_detect pcd_checker #(.NPINS(NPINS)) i_pcd_checker (
  .clk       (clk),
  .sys_rst_n (sys_rst_n_s),
  .por_rst_n (por_rst_n_s),
  .mism      (any_mism),
  .clr       (clr_i),
  .flag      (flag_o),
  .acc       (port_acc_i),
  .vld       (snap_vld),
  .pins      (pins_i),
  .snap      (snap_q)
);

// File: tb/test_pin_change_detect.sv
module test_pin_change_detect;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 6;
  localparam int NROWS      = 14;

  logic          clk = 1'b0;
  logic          por_n, rst_n;
  logic [NP-1:0] pins, en_d;
  logic          en_we, acc, clr;
  logic          flag, wake;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_detect #(.NPINS(NP)) i_pin_change_detect (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .pins_i     (pins),
    .en_we_i    (en_we),
    .en_d_i     (en_d),
    .port_acc_i (acc),
    .clr_i      (clr),
    .flag_o     (flag),
    .wake_o     (wake)
  );

  // Row fields: en_we, en_d, pins, acc, clr, expected flag, requirement number.
  localparam logic [19:0] TBL [0:NROWS-1] = '{
    {1'b1, 6'h3F, 6'h00, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 enable all, no change
    {1'b0, 6'h00, 6'h01, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 pin0 moves
    {1'b0, 6'h00, 6'h01, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 clear loses to live difference
    {1'b0, 6'h00, 6'h01, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 access refreshes copy
    {1'b0, 6'h00, 6'h01, 1'b0, 1'b1, 1'b0, 4'd4}, // R4 clear now works
    {1'b0, 6'h00, 6'h01, 1'b0, 1'b0, 1'b0, 4'd9}, // R9 stays clear
    {1'b1, 6'h1E, 6'h01, 1'b0, 1'b0, 1'b0, 4'd1}, // R1 disable pin0
    {1'b0, 6'h00, 6'h00, 1'b0, 1'b0, 1'b0, 4'd2}, // R2 disabled pin ignored
    {1'b0, 6'h00, 6'h02, 1'b0, 1'b0, 1'b1, 4'd3}, // R3 pin1 moves
    {1'b0, 6'h00, 6'h02, 1'b0, 1'b0, 1'b1, 4'd9}, // R9 sticky
    {1'b0, 6'h00, 6'h06, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 change coincides with access
    {1'b0, 6'h00, 6'h06, 1'b0, 1'b1, 1'b0, 4'd5}, // R5 copy holds access-cycle pins
    {1'b0, 6'h00, 6'h04, 1'b1, 1'b1, 1'b1, 4'd4}, // R4 set beats clear
    {1'b0, 6'h00, 6'h04, 1'b0, 1'b1, 1'b0, 4'd4}  // R4 clear after access
  };

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {wake,flag} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    en_we = 1'b0; acc = 1'b0; clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements R1..R9 unfinished)");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; pins = '0; en_d = '0;
    idle();
    repeat (3) @(negedge clk);
    check("R7 power-on reset state", {wake, flag}, 2'b00);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 after power-on release", {wake, flag}, 2'b00);

    // Table walk: apply at a falling edge, check at the next falling edge.
    for (int i = 0; i < NROWS; i++) begin
      en_we = TBL[i][19];
      en_d  = TBL[i][18:13];
      pins  = TBL[i][12:7];
      acc   = TBL[i][6];
      clr   = TBL[i][5];
      @(negedge clk);
      idle();
      checks++;
      if ({wake, flag} !== {2{TBL[i][4]}}) begin
        failures++;
        $display("FAIL row %0d (req R%0d; wake R8): {wake,flag} actual=%b expected=%b",
                 i, TBL[i][3:0], {wake, flag}, {2{TBL[i][4]}});
      end
    end

    // R6: general reset keeps copy (04) and mask (1E); pin3 moves during reset.
    pins  = 6'h0C;
    rst_n = 1'b0;
    @(negedge clk);
    check("R6 flag low in general reset", {wake, flag}, 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R6 flag re-set after release", {wake, flag}, 2'b11);
    acc = 1'b1;
    @(negedge clk);
    idle();
    clr = 1'b1;
    @(negedge clk);
    idle();
    check("R5 access then clear", {wake, flag}, 2'b00);

    // R7: power-on reset clears mask and loads copy from pins (3F).
    pins  = 6'h3F;
    por_n = 1'b0;
    @(negedge clk);
    check("R7 flag low in power-on reset", {wake, flag}, 2'b00);
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7 no flag after release", {wake, flag}, 2'b00);
    pins = 6'h00;
    repeat (2) @(negedge clk);
    check("R7 mask cleared, changes ignored", {wake, flag}, 2'b00);
    en_we = 1'b1; en_d = 6'h3F;
    @(negedge clk);
    idle();
    check("R1 new mask not yet active", {wake, flag}, 2'b00);
    @(negedge clk);
    check("R7 copy held pins from release", {wake, flag}, 2'b11);

    finish_run();
  end

endmodule